// File: doc/BRIEF.md
# Dual-Issue In-Order Instruction Buffer

This block decouples the fetch stage of a two-pipeline in-order core from its two decode lanes. Fetch delivers a pair of consecutive 32-bit instructions (the one at the fetch PC and the one after it) together with the PC. The pair is written into a small circular queue only when the queue can hold both entries. Every entry keeps its own PC and a class tag (ALU, control transfer, load/store) that is derived from the opcode field when the entry is written.

Each cycle the oldest entry is offered to lane 0 and the entry behind it is offered to lane 1. Lane 1 has no memory port, so a load/store entry is never offered there; it waits until it reaches the head and lane 0 takes it. Each lane answers with a take signal. Lane 1 can only take in the same cycle as lane 0, so entries leave from the head in program order, zero, one or two per cycle. An entry that is not taken stays where it is and is offered again in the next cycle.

When either pipeline resolves a control transfer, every buffered entry is discarded. A pair fetched in that same cycle is dropped as well. A control transfer from pipeline 0 also raises a kill for the instruction in pipeline 1's memory stage during that same cycle.

Top module: `dual_issue_ibuf`

## Requirements
- R1: A synchronous active-high reset empties the buffer. After the reset edge both lane valid outputs are low and `fetch_ready` is high.
- R2: `fetch_ready` is high exactly when at most DEPTH-2 entries are held (DEPTH is 4 by default). A pair is stored only in a cycle with `fetch_valid` and `fetch_ready` high and no flush. Otherwise nothing is stored.
- R3: A stored pair becomes two entries. The first entry has PC `fetch_pc` and `fetch_instr0`. The second has PC `fetch_pc`+4 and `fetch_instr1`. Each lane outputs the PC of the entry it presents.
- R4: An offered entry whose lane does not take it stays in the buffer and is offered again, unchanged, in the next cycle.
- R5: Lane 1 is never valid while the entry behind the head is a load/store, which is an opcode (bits 31:26) with bit 5 set.
- R6: Lane 1 removes its entry only in a cycle in which lane 0 also takes. A `lane1_take` without `lane0_take` has no effect.
- R7: A high `flush0` or `flush1` empties the buffer at the next edge, and a pair offered in the same cycle is dropped.
- R8: `kill_p1_mem` is high in exactly the cycles in which `flush0` is high. `flush1` does not raise it.
- R9: The class output of a lane is 2'b10 for a load/store opcode (bit 5 set). It is 2'b01 for a control-transfer opcode (bits 5:4 = 01) and 2'b00 for an ALU opcode (bits 5:4 = 00).
- R10: Lane 0 always presents the oldest held entry and lane 1 the next older one. When two entries leave together, the entry that was third oldest becomes the new head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch offers a pair this cycle |
| fetch_pc | input | 32 | PC of the first instruction of the pair |
| fetch_instr0 | input | 32 | Instruction at `fetch_pc` |
| fetch_instr1 | input | 32 | Instruction following it |
| fetch_ready | output | 1 | Room for a whole pair; fetch holds its PC while low |
| flush0 | input | 1 | Control transfer resolved in pipeline 0 |
| flush1 | input | 1 | Control transfer resolved in pipeline 1 |
| kill_p1_mem | output | 1 | Discard pipeline 1's memory-stage instruction |
| lane0_valid | output | 1 | Lane 0 entry present |
| lane0_instr | output | 32 | Lane 0 instruction |
| lane0_pc | output | 32 | Lane 0 PC |
| lane0_class | output | 2 | Lane 0 class tag |
| lane0_take | input | 1 | Lane 0 accepts its entry |
| lane1_valid | output | 1 | Lane 1 entry present |
| lane1_instr | output | 32 | Lane 1 instruction |
| lane1_pc | output | 32 | Lane 1 PC |
| lane1_class | output | 2 | Lane 1 class tag |
| lane1_take | input | 1 | Lane 1 accepts its entry |

## Verification
Random cycles mix random opcodes of all three classes with random take and flush patterns, so the buffer moves through every fill level. This shows whether zero, one or two entries leave correctly and whether load/store entries are held back from lane 1. Directed sequences fill the buffer until `fetch_ready` drops, so that a stored pair can be told apart from a dropped one. They also stall lane 0 while lane 1 asserts take, which shows whether an out-of-order removal happens. A flush is issued in the same cycle as a fetch, and flushes from the two pipelines are compared to show which one raises the kill. A load/store is placed behind an ALU entry so that lane 1's restriction is visible at the ports.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
   typedef enum logic [1:0] {
      ICLS_ALU  = 2'b00,
      ICLS_CTRL = 2'b01,
      ICLS_MEM  = 2'b10
   } iclass_e;
endpackage

// File: rtl/ibuf_classify.sv
module ibuf_classify #(
   parameter int ILEN   = 32,
   parameter int OP_MSB = 31,
   parameter int OP_W   = 6
) (
   input  logic [ILEN-1:0]   instr,
   output ibuf_pkg::iclass_e cls
);
   if (OP_W < 2 || OP_MSB >= ILEN || OP_MSB - OP_W + 1 < 0) begin : g_bad_op
      $error("ibuf_classify: opcode field does not fit the instruction");
   end

   logic [OP_W-1:0] opc;
   assign opc = instr[OP_MSB -: OP_W];

   always_comb begin
      if (opc[OP_W-1])      cls = ibuf_pkg::ICLS_MEM;
      else if (opc[OP_W-2]) cls = ibuf_pkg::ICLS_CTRL;
      else                  cls = ibuf_pkg::ICLS_ALU;
   end
endmodule

// File: rtl/ibuf_ring.sv
module ibuf_ring #(
   parameter int AW    = 32,
   parameter int ILEN  = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_pc0,
   input  logic [ILEN-1:0]   wr_ins0,
   input  ibuf_pkg::iclass_e wr_cls0,
   input  logic [AW-1:0]     wr_pc1,
   input  logic [ILEN-1:0]   wr_ins1,
   input  ibuf_pkg::iclass_e wr_cls1,
   input  logic [1:0]        pop_n,
   output logic [CW-1:0]     occ,
   output logic [AW-1:0]     hd0_pc,
   output logic [ILEN-1:0]   hd0_ins,
   output ibuf_pkg::iclass_e hd0_cls,
   output logic [AW-1:0]     hd1_pc,
   output logic [ILEN-1:0]   hd1_ins,
   output ibuf_pkg::iclass_e hd1_cls
);
   typedef struct packed {
      logic [AW-1:0]     pc;
      logic [ILEN-1:0]   ins;
      ibuf_pkg::iclass_e cls;
   } slot_t;

   slot_t            slots [DEPTH];
   logic [PW-1:0]    head, tail, tail_nx, head_nx;
   slot_t            in0, in1;

   assign in0     = '{pc: wr_pc0, ins: wr_ins0, cls: wr_cls0};
   assign in1     = '{pc: wr_pc1, ins: wr_ins1, cls: wr_cls1};
   assign tail_nx = tail + PW'(1);
   assign head_nx = head + PW'(1);

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         head <= '0;
         tail <= '0;
         occ  <= '0;
      end else begin
         head <= head + PW'(pop_n);
         if (wr_en) tail <= tail_nx + PW'(1);
         occ  <= occ - CW'(pop_n) + (wr_en ? CW'(2) : CW'(0));
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && tail == PW'(i))         slots[i] <= in0;
         else if (wr_en && tail_nx == PW'(i)) slots[i] <= in1;
      end
   end

   slot_t rd0, rd1;
   assign rd0     = slots[head];
   assign rd1     = slots[head_nx];
   assign hd0_pc  = rd0.pc;
   assign hd0_ins = rd0.ins;
   assign hd0_cls = rd0.cls;
   assign hd1_pc  = rd1.pc;
   assign hd1_ins = rd1.ins;
   assign hd1_cls = rd1.cls;
endmodule

// File: rtl/ibuf_issue.sv
module ibuf_issue #(
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic [CW-1:0]     occ,
   input  ibuf_pkg::iclass_e hd1_cls,
   input  logic              take0,
   input  logic              take1,
   output logic              l0_valid,
   output logic              l1_valid,
   output logic [1:0]        pop_n,
   output logic              room_pair
);
   logic go0, go1;

   assign l0_valid  = occ != '0;
   assign l1_valid  = (occ >= CW'(2)) && (hd1_cls != ibuf_pkg::ICLS_MEM);
   assign go0       = l0_valid && take0;
   assign go1       = go0 && l1_valid && take1;
   assign pop_n     = {go1, go0 && !go1};
   assign room_pair = occ <= CW'(DEPTH - 2);
endmodule

// File: rtl/dual_issue_ibuf.sv
module dual_issue_ibuf #(
   parameter int AW     = 32,
   parameter int ILEN   = 32,
   parameter int DEPTH  = 4,
   parameter int OP_MSB = 31,
   parameter int OP_W   = 6,
   localparam int STEP  = ILEN / 8,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            fetch_valid,
   input  logic [AW-1:0]   fetch_pc,
   input  logic [ILEN-1:0] fetch_instr0,
   input  logic [ILEN-1:0] fetch_instr1,
   output logic            fetch_ready,
   input  logic            flush0,
   input  logic            flush1,
   output logic            kill_p1_mem,
   output logic            lane0_valid,
   output logic [ILEN-1:0] lane0_instr,
   output logic [AW-1:0]   lane0_pc,
   output logic [1:0]      lane0_class,
   input  logic            lane0_take,
   output logic            lane1_valid,
   output logic [ILEN-1:0] lane1_instr,
   output logic [AW-1:0]   lane1_pc,
   output logic [1:0]      lane1_class,
   input  logic            lane1_take
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dual_issue_ibuf: DEPTH must be a power of two of at least 2");
   end
   if (ILEN % 8 != 0) begin : g_bad_ilen
      $error("dual_issue_ibuf: ILEN must be a whole number of bytes");
   end

   ibuf_pkg::iclass_e cls_in [2];
   logic [ILEN-1:0]   ins_in [2];
   assign ins_in[0] = fetch_instr0;
   assign ins_in[1] = fetch_instr1;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      ibuf_classify #(.ILEN(ILEN), .OP_MSB(OP_MSB), .OP_W(OP_W)) u_cls (
         .instr (ins_in[k]),
         .cls   (cls_in[k])
      );
   end

   logic              flush_any, wr_en;
   logic [1:0]        pop_n;
   logic [CW-1:0]     occ;
   ibuf_pkg::iclass_e hd0_cls, hd1_cls;

   assign flush_any   = flush0 || flush1;
   assign wr_en       = fetch_valid && fetch_ready && !flush_any;
   assign kill_p1_mem = flush0;

   ibuf_ring #(.AW(AW), .ILEN(ILEN), .DEPTH(DEPTH)) u_ring (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush_any),
      .wr_en   (wr_en),
      .wr_pc0  (fetch_pc),
      .wr_ins0 (fetch_instr0),
      .wr_cls0 (cls_in[0]),
      .wr_pc1  (fetch_pc + AW'(STEP)),
      .wr_ins1 (fetch_instr1),
      .wr_cls1 (cls_in[1]),
      .pop_n   (pop_n),
      .occ     (occ),
      .hd0_pc  (lane0_pc),
      .hd0_ins (lane0_instr),
      .hd0_cls (hd0_cls),
      .hd1_pc  (lane1_pc),
      .hd1_ins (lane1_instr),
      .hd1_cls (hd1_cls)
   );

   ibuf_issue #(.DEPTH(DEPTH)) u_issue (
      .occ       (occ),
      .hd1_cls   (hd1_cls),
      .take0     (lane0_take),
      .take1     (lane1_take),
      .l0_valid  (lane0_valid),
      .l1_valid  (lane1_valid),
      .pop_n     (pop_n),
      .room_pair (fetch_ready)
   );

   assign lane0_class = hd0_cls;
   assign lane1_class = hd1_cls;
endmodule

// File: rtl/ibuf_chk.sv
module ibuf_chk #(
   parameter int AW   = 32,
   parameter int ILEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            flush0,
   input logic            flush1,
   input logic            fetch_ready,
   input logic            lane0_valid,
   input logic            lane0_take,
   input logic [ILEN-1:0] lane0_instr,
   input logic [AW-1:0]   lane0_pc,
   input logic            lane1_valid,
   input logic [ILEN-1:0] lane1_instr,
   input logic [1:0]      lane1_class
);
   AST_RESET_EMPTY: assert property (@(posedge clk)
      rst |=> !lane0_valid && !lane1_valid && fetch_ready);                    // R1
   AST_L1_NO_MEM: assert property (@(posedge clk) disable iff (rst)
      lane1_valid |-> !lane1_instr[ILEN-1] && lane1_class != 2'b10);           // R5
   AST_L1_BEHIND_L0: assert property (@(posedge clk) disable iff (rst)
      lane1_valid |-> lane0_valid);                                            // R10
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      lane0_valid && !lane0_take && !flush0 && !flush1
      |=> lane0_valid && $stable(lane0_pc) && $stable(lane0_instr));           // R4
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
      flush0 || flush1 |=> !lane0_valid && !lane1_valid && fetch_ready);       // R7
   AST_FULL_HAS_HEAD: assert property (@(posedge clk) disable iff (rst)
      !fetch_ready |-> lane0_valid);                                           // R2
endmodule

bind dual_issue_ibuf ibuf_chk #(.AW(AW), .ILEN(ILEN)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .flush0      (flush0),
   .flush1      (flush1),
   .fetch_ready (fetch_ready),
   .lane0_valid (lane0_valid),
   .lane0_take  (lane0_take),
   .lane0_instr (lane0_instr),
   .lane0_pc    (lane0_pc),
   .lane1_valid (lane1_valid),
   .lane1_instr (lane1_instr),
   .lane1_class (lane1_class)
);

// File: tb/tb_dual_issue_ibuf.sv
`timescale 1ns/1ps
module tb_dual_issue_ibuf;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0, fetch_instr0 = '0, fetch_instr1 = '0;
   logic        fetch_ready, kill_p1_mem;
   logic        flush0 = 1'b0, flush1 = 1'b0;
   logic        lane0_valid, lane1_valid;
   logic [31:0] lane0_instr, lane0_pc, lane1_instr, lane1_pc;
   logic [1:0]  lane0_class, lane1_class;
   logic        lane0_take = 1'b0, lane1_take = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dual_issue_ibuf #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .fetch_instr0(fetch_instr0), .fetch_instr1(fetch_instr1),
      .fetch_ready(fetch_ready), .flush0(flush0), .flush1(flush1),
      .kill_p1_mem(kill_p1_mem), .lane0_valid(lane0_valid),
      .lane0_instr(lane0_instr), .lane0_pc(lane0_pc), .lane0_class(lane0_class),
      .lane0_take(lane0_take), .lane1_valid(lane1_valid),
      .lane1_instr(lane1_instr), .lane1_pc(lane1_pc), .lane1_class(lane1_class),
      .lane1_take(lane1_take)
   );

   // reference queue
   logic [31:0] m_pc [8];
   logic [31:0] m_in [8];
   int          m_cnt = 0;

   function automatic logic [1:0] ref_cls(input logic [31:0] ins);
      if (ins[31])      return 2'b10;
      else if (ins[30]) return 2'b01;
      else              return 2'b00;
   endfunction

   function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] rest);
      return {op, rest};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      bit e0, e1;
      e0 = m_cnt >= 1;
      e1 = (m_cnt >= 2) && (ref_cls(m_in[1]) != 2'b10);
      chk(tag, "fetch_ready", 64'(fetch_ready), 64'(m_cnt <= DEPTH - 2));
      chk(tag, "kill_p1_mem", 64'(kill_p1_mem), 64'(flush0));
      chk(tag, "lane0_valid", 64'(lane0_valid), 64'(e0));
      chk(tag, "lane1_valid", 64'(lane1_valid), 64'(e1));
      if (e0) begin
         chk(tag, "lane0_instr", 64'(lane0_instr), 64'(m_in[0]));
         chk(tag, "lane0_pc",    64'(lane0_pc),    64'(m_pc[0]));
         chk(tag, "lane0_class", 64'(lane0_class), 64'(ref_cls(m_in[0])));
      end
      if (e1) begin
         chk(tag, "lane1_instr", 64'(lane1_instr), 64'(m_in[1]));
         chk(tag, "lane1_pc",    64'(lane1_pc),    64'(m_pc[1]));
         chk(tag, "lane1_class", 64'(lane1_class), 64'(ref_cls(m_in[1])));
      end
   endtask

   task automatic model_step();
      bit e0, e1, rdy;
      int p;
      e0  = m_cnt >= 1;
      e1  = (m_cnt >= 2) && (ref_cls(m_in[1]) != 2'b10);
      rdy = m_cnt <= DEPTH - 2;
      if (rst || flush0 || flush1) begin
         m_cnt = 0;
      end else begin
         p = (e0 && lane0_take) ? ((e1 && lane1_take) ? 2 : 1) : 0;
         for (int i = 0; i < 6; i++) begin
            m_pc[i] = m_pc[i+p];
            m_in[i] = m_in[i+p];
         end
         m_cnt -= p;
         if (fetch_valid && rdy) begin
            m_pc[m_cnt] = fetch_pc;      m_in[m_cnt] = fetch_instr0;
            m_pc[m_cnt+1] = fetch_pc + 4; m_in[m_cnt+1] = fetch_instr1;
            m_cnt += 2;
         end
      end
   endtask

   // called at a falling edge with inputs already set
   task automatic tick(input string tag);
      #1;
      if (!rst) compare(tag);
      model_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drive(input bit fv, input logic [31:0] pc,
                        input logic [31:0] i0, input logic [31:0] i1,
                        input bit t0, input bit t1, input bit f0, input bit f1);
      fetch_valid = fv; fetch_pc = pc; fetch_instr0 = i0; fetch_instr1 = i1;
      lane0_take = t0; lane1_take = t1; flush0 = f0; flush1 = f1;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin m_pc[i] = '0; m_in[i] = '0; end
      @(negedge clk);
      rst = 1'b1;
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      tick("R1"); tick("R1");
      rst = 1'b0;
      tick("R1");                                   // empty after reset

      // fill with ALU pairs, no takes: 0 -> 2 -> 4, third pair refused
      drive(1, 32'h100, mk(6'h01, 26'h11), mk(6'h02, 26'h22), 0, 0, 0, 0);
      tick("R3");
      drive(1, 32'h108, mk(6'h03, 26'h33), mk(6'h04, 26'h44), 0, 0, 0, 0);
      tick("R2");
      drive(1, 32'h110, mk(6'h05, 26'h55), mk(6'h06, 26'h66), 0, 0, 0, 0);
      tick("R2");                                   // full: pair dropped
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      tick("R4");                                   // held, re-offered
      drive(0, 0, 0, 0, 0, 1, 0, 0);
      tick("R6");                                   // lane1 take alone
      tick("R6");
      drive(0, 0, 0, 0, 1, 1, 0, 0);
      tick("R10");                                  // two leave together
      drive(0, 0, 0, 0, 1, 0, 0, 0);
      tick("R10");                                  // one leaves
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      tick("R10");

      // flush from pipeline 0 together with a fetch
      drive(1, 32'h200, mk(6'h07, 0), mk(6'h08, 0), 0, 0, 1, 0);
      tick("R8");
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      tick("R7");

      // load/store behind an ALU entry
      drive(1, 32'h300, mk(6'h09, 26'h1), mk(6'h23, 26'h2), 0, 0, 0, 0);
      tick("R9");
      drive(0, 0, 0, 0, 0, 1, 0, 0);
      tick("R5");
      drive(0, 0, 0, 0, 1, 1, 0, 0);
      tick("R5");                                   // only lane 0 leaves
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      tick("R9");                                   // mem now at head
      // control-transfer pair, flush from pipeline 1
      drive(1, 32'h400, mk(6'h10, 0), mk(6'h1f, 0), 0, 0, 0, 0);
      tick("R9");
      drive(0, 0, 0, 0, 0, 0, 0, 1);
      tick("R8");                                   // no kill from pipe 1
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      tick("R7");

      // constrained random
      void'($urandom(32'd20240611));
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         r = $urandom;
         drive(r[0] | r[1], {$urandom} & 32'hffff_fffc, $urandom, $urandom,
               r[2] | r[3], r[4], (r[15:10] == 0), (r[21:16] == 0));
         if (r[31:22] == 0) rst = 1'b1;
         tick(rst ? "R1" : "R10");
         rst = 1'b0;
      end

      done = 1'b1;
      finish_run();
   end
endmodule